// File: doc/BRIEF.md
# Dual-Queue Streaming Multiply-Accumulate Stage

This block is a compute stage that sits between two input queues and one output queue. It sees the head entry of each input queue on its data ports, as a show-ahead queue presents it. When both input queues hold data and the output queue can take a write, the stage removes one entry from each input in the same cycle. It multiplies the pair and adds the product to a wide signed accumulator. It then rounds the new total by a programmable right shift, clamps it to the signed output range and writes it to the output queue in that same cycle. Operands go from the queue ports straight into the arithmetic, with no memory access in between.

Each cycle has one decision, called fire, that drives both pop strobes and the write strobe together. A single input is never consumed alone. A full output queue holds back the whole operation, so no entries are lost and the running total is kept. A clear input zeroes the running total, either on its own or as the starting value for an operation in the same cycle. With all three queues ready on every cycle, the stage delivers one result per cycle.

Top module: `fifo_mac_stage`

## Requirements
- R1: After synchronous active-high reset the accumulator is zero, so the first result after reset with shift 0 equals the product of the first pair.
- R2: Both pop strobes are asserted together, and only in a cycle where neither input queue is empty and the output queue is not full.
- R3: The write strobe is asserted in exactly the cycles in which the pops are asserted, and the result is presented on out_data in that cycle.
- R4: In a cycle with no fire and no clear, the accumulator keeps its value, so a stall caused by an empty input or a full output loses no running total.
- R5: On fire, the accumulator becomes base + a*b, wrapped to 40 bits. Here base is zero when clear is high and the stored total otherwise, and a and b are signed 16-bit operands.
- R6: The result is (total + 2^(s-1)) shifted arithmetically right by s, where s is the 5-bit shift input (0 to 31); with s = 0 no rounding term is added.
- R7: The rounded value is clamped to the range -32768 to 32767 and never wraps.
- R8: A clear without fire sets the accumulator to zero; a clear with fire makes the result and the new total start from zero.
- R9: When both inputs are non-empty and the output is not full on consecutive cycles, a result is written on every one of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_empty | input | 1 | Input queue A has no entry |
| a_data | input | 16 | Head entry of queue A, signed |
| a_pop | output | 1 | Removes the head entry of queue A |
| b_empty | input | 1 | Input queue B has no entry |
| b_data | input | 16 | Head entry of queue B, signed |
| b_pop | output | 1 | Removes the head entry of queue B |
| out_full | input | 1 | Output queue cannot accept a write |
| out_wr | output | 1 | Writes out_data into the output queue |
| out_data | output | 16 | Rounded, saturated result |
| acc_clear | input | 1 | Zero the accumulator / start a fresh total |
| rnd_shift | input | 5 | Rounding right-shift amount, 0 to 31 |

## Verification
The bench builds the block with its default parameters: 16-bit operands, a 40-bit accumulator and a 5-bit shift. With these values, directed cases at the extreme operand -32768 reach saturation at both ends of the output range. A shift of 31 brings the top bits of the accumulator into the output. Random runs drive independent empty, full and clear patterns with all shift values. These runs let the total drift over many operations, so that stalls, clears and rounding of both signs all occur against a running total the bench models itself.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ACC_W   = 40;
  localparam int unsigned SHIFT_W = 5;
  localparam int unsigned OUT_W   = 16;
endpackage

// File: rtl/fms_handshake.sv
module fms_handshake (
  input  logic a_empty,
  input  logic b_empty,
  input  logic out_full,
  output logic fire
);
  // One decision moves both inputs and the output together.
  always_comb begin
    fire = !a_empty && !b_empty && !out_full;
  end
endmodule

// File: rtl/fms_accum.sv
module fms_accum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic                     clear,
  input  logic signed [DATA_W-1:0] a_in,
  input  logic signed [DATA_W-1:0] b_in,
  output logic signed [ACC_W-1:0]  sum,
  output logic signed [ACC_W-1:0]  acc_q
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  base;

  always_comb begin
    prod     = a_in * b_in;
    prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    base     = clear ? '0 : acc_q;
    sum      = base + prod_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (fire) begin
      acc_q <= sum;
    end else if (clear) begin
      acc_q <= '0;
    end
  end
endmodule

// File: rtl/fms_round_sat.sv
module fms_round_sat #(
  parameter int unsigned ACC_W   = 40,
  parameter int unsigned SHIFT_W = 5,
  parameter int unsigned OUT_W   = 16
) (
  input  logic signed [ACC_W-1:0]   sum,
  input  logic        [SHIFT_W-1:0] shift,
  output logic signed [OUT_W-1:0]   result
);
  localparam int unsigned EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - EXT_W'(1);

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] half;
  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] shifted;

  always_comb begin
    ext     = {sum[ACC_W-1], sum};
    half    = (shift == '0) ? '0 : (EXT_W'(1) << (shift - SHIFT_W'(1)));
    biased  = ext + half;
    shifted = biased >>> shift;
    if (shifted > MAX_V) begin
      result = MAX_V[OUT_W-1:0];
    end else if (shifted < MIN_V) begin
      result = MIN_V[OUT_W-1:0];
    end else begin
      result = shifted[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/fifo_mac_stage.sv
module fifo_mac_stage #(
  parameter int unsigned DATA_W  = fms_pkg::DATA_W,
  parameter int unsigned ACC_W   = fms_pkg::ACC_W,
  parameter int unsigned SHIFT_W = fms_pkg::SHIFT_W,
  parameter int unsigned OUT_W   = fms_pkg::OUT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_empty,
  input  logic [DATA_W-1:0]  a_data,
  output logic               a_pop,
  input  logic               b_empty,
  input  logic [DATA_W-1:0]  b_data,
  output logic               b_pop,
  input  logic               out_full,
  output logic               out_wr,
  output logic [OUT_W-1:0]   out_data,
  input  logic               acc_clear,
  input  logic [SHIFT_W-1:0] rnd_shift
);
  logic                    fire;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [OUT_W-1:0] result;

  fms_handshake u_hs (
    .a_empty  (a_empty),
    .b_empty  (b_empty),
    .out_full (out_full),
    .fire     (fire)
  );

  fms_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .clear (acc_clear),
    .a_in  ($signed(a_data)),
    .b_in  ($signed(b_data)),
    .sum   (sum),
    .acc_q (acc_q)
  );

  fms_round_sat #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) u_rnd (
    .sum    (sum),
    .shift  (rnd_shift),
    .result (result)
  );

  always_comb begin
    a_pop    = fire;
    b_pop    = fire;
    out_wr   = fire;
    out_data = result;
  end
endmodule

// File: rtl/fifo_mac_stage_chk.sv
module fifo_mac_stage_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             a_empty,
  input logic             b_empty,
  input logic             out_full,
  input logic             a_pop,
  input logic             b_pop,
  input logic             out_wr,
  input logic             acc_clear,
  input logic [ACC_W-1:0] acc_q
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R1
  AST_POP_GUARD: assert property (@(posedge clk) disable iff (rst) (a_pop || b_pop) |-> (!a_empty && !b_empty && !out_full)); // R2
  AST_POP_PAIR: assert property (@(posedge clk) disable iff (rst) a_pop |-> b_pop); // R2
  AST_WR_WITH_POP: assert property (@(posedge clk) disable iff (rst) out_wr |-> (a_pop && b_pop)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (!out_wr && !acc_clear) |=> $stable(acc_q)); // R4
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst) (acc_clear && !out_wr) |=> (acc_q == '0)); // R8
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst) (!a_empty && !b_empty && !out_full) |-> out_wr); // R9
endmodule

bind fifo_mac_stage fifo_mac_stage_chk #(.ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .a_empty   (a_empty),
  .b_empty   (b_empty),
  .out_full  (out_full),
  .a_pop     (a_pop),
  .b_pop     (b_pop),
  .out_wr    (out_wr),
  .acc_clear (acc_clear),
  .acc_q     (acc_q)
);

// File: tb/fifo_mac_stage_tb_top.sv
module fifo_mac_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_empty = 1'b1;
  logic [15:0] a_data = '0;
  logic        a_pop;
  logic        b_empty = 1'b1;
  logic [15:0] b_data = '0;
  logic        b_pop;
  logic        out_full = 1'b0;
  logic        out_wr;
  logic [15:0] out_data;
  logic        acc_clear = 1'b0;
  logic [4:0]  rnd_shift = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic signed [39:0] m_acc = '0;
  int run_len  = 0;

  always #4 clk = ~clk;

  fifo_mac_stage dut_i (
    .clk(clk), .rst(rst),
    .a_empty(a_empty), .a_data(a_data), .a_pop(a_pop),
    .b_empty(b_empty), .b_data(b_data), .b_pop(b_pop),
    .out_full(out_full), .out_wr(out_wr), .out_data(out_data),
    .acc_clear(acc_clear), .rnd_shift(rnd_shift)
  );

  function automatic logic signed [15:0] round_sat(input logic signed [63:0] v, input int sh);
    logic signed [63:0] r;
    if (sh == 0) r = v;
    else r = (v + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > 64'sd32767) r = 64'sd32767;
    if (r < -64'sd32768) r = -64'sd32768;
    return r[15:0];
  endfunction

  task automatic ck(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model at posedge.
  task automatic step(input logic signed [15:0] a, input logic signed [15:0] b,
                      input logic ae, input logic be, input logic full,
                      input logic clr, input int sh, input string req);
    logic fire;
    logic signed [63:0] base;
    logic signed [63:0] tot;
    logic signed [39:0] nxt;
    @(negedge clk);
    a_data = a; b_data = b; a_empty = ae; b_empty = be;
    out_full = full; acc_clear = clr; rnd_shift = 5'(sh);
    #1;
    fire = !ae && !be && !full;
    base = clr ? 64'sd0 : 64'(m_acc);
    tot  = base + 64'(a) * 64'(b);
    nxt  = tot[39:0];
    ck(a_pop == fire && b_pop == fire, {req, " R2 pops"}, longint'({a_pop, b_pop}), longint'({fire, fire}));
    ck(out_wr == fire, {req, " R3 write"}, longint'(out_wr), longint'(fire));
    if (fire) begin
      ck($signed(out_data) == round_sat(64'(nxt), sh), {req, " R5 data"},
         longint'($signed(out_data)), longint'(round_sat(64'(nxt), sh)));
      run_len++;
    end else begin
      run_len = 0;
    end
    @(posedge clk);
    if (fire) m_acc = nxt;
    else if (clr) m_acc = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_acc = '0;
    #1;
    // R1: idle after reset, no strobes
    ck(out_wr == 1'b0 && a_pop == 1'b0, "R1 idle strobes", longint'(out_wr), 0);
    // R1: first result equals product (acc zero)
    step(16'sd3, 16'sd4, 0, 0, 0, 0, 0, "R1 first");
    ck(m_acc == 40'sd12, "R1 model", longint'(m_acc), 12);
    // R2/R4: empty A, empty B, full output stall and keep total
    step(16'sd100, 16'sd100, 1, 0, 0, 0, 0, "R2 a empty");
    step(16'sd100, 16'sd100, 0, 1, 0, 0, 0, "R2 b empty");
    step(16'sd100, 16'sd100, 0, 0, 1, 0, 0, "R4 full stall");
    step(16'sd1, 16'sd1, 0, 0, 0, 0, 0, "R4 held total");   // expects 13
    // R8: clear without fire, then accumulate from zero
    step(16'sd9, 16'sd9, 1, 1, 0, 1, 0, "R8 idle clear");
    step(16'sd2, 16'sd5, 0, 0, 0, 0, 0, "R8 after clear");  // expects 10
    step(16'sd7, 16'sd1, 0, 0, 0, 1, 0, "R8 clear with fire"); // expects 7
    // R6: rounding of both signs
    step(16'sd3, 16'sd1, 0, 0, 0, 1, 1, "R6 pos round");   // (3+1)>>1 = 2
    step(-16'sd3, 16'sd1, 0, 0, 0, 1, 1, "R6 neg round");  // (-3+1)>>>1 = -1
    step(-16'sd32768, -16'sd32768, 0, 0, 0, 1, 31, "R6 shift31"); // 2^30 -> 1
    // R7: saturation both ends
    step(-16'sd32768, -16'sd32768, 0, 0, 0, 1, 0, "R7 high sat");
    step(-16'sd32768, 16'sd32767, 0, 0, 0, 1, 0, "R7 low sat");
    // R9: sustained full rate
    run_len = 0;
    for (int i = 0; i < 16; i++)
      step(16'($urandom), 16'($urandom), 0, 0, 0, 0, int'($urandom % 32), "R9 stream");
    ck(run_len == 16, "R9 run length", longint'(run_len), 16);
    // Random mix covering R2..R8
    for (int i = 0; i < 3000; i++) begin
      step(16'($urandom), 16'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 40) == 0, int'($urandom % 32), "R5 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule